// File: doc/BRIEF.md
# Receive FIFO with Threshold DMA Request

This block is a receive-side word FIFO that sits between a serial pin interface, which pushes audio words in, and a DMA engine, which pops them out. Software sets a threshold in words. Each time the pin side completes a group of that many accepted writes, the block owes the DMA one service request. Each time the DMA completes a group of that many reads, one owed request is paid off. The request output is a level. It stays high while at least one group is owed.

The block keeps a count of owed groups instead of a single set/clear flip-flop. This means a group completing on the pin side and a group completing on the DMA side in the same cycle, or in neighbouring cycles, cancel cleanly. The request is never dropped. When the DMA falls behind and the FIFO fills, the block drops further incoming words and raises a sticky overflow flag, which software clears with a write-one-to-clear pulse. An enable input returns the whole data path to empty when it is low.

Top module: `rxq_dma_event`

## Requirements
- R1: After reset the FIFO is empty (`level` 0), `dma_req` is 0 and `ovf_flag` is 0.
- R2: Accepted words leave in arrival order. `rd_data` always shows the oldest stored word, and `level` counts stored words up to `DEPTH`.
- R3: When an accepted write completes a group of threshold writes, one request is added to the owed count, and `dma_req` is 1 from the next cycle.
- R4: When an accepted read completes a group of threshold reads, one request is removed from the owed count. `dma_req` falls in the cycle after the owed count reaches zero.
- R5: When a write group and a read group complete in the same cycle, the owed count is unchanged, so an asserted `dma_req` stays asserted.
- R6: The effective threshold is `thr_cfg`, except that a value of 0 acts as 1 and any value above `DEPTH` acts as `DEPTH`.
- R7: A write offered while the FIFO holds `DEPTH` words is dropped and sets `ovf_flag`. This holds even if a read happens in the same cycle.
- R8: `ovf_flag` stays set until a cycle with `ovf_clr` = 1. If a new overflow happens in that same cycle, the flag stays set.
- R9: While `enable` is 0, the FIFO, both group counters and the owed count are cleared, `dma_req` is 0, writes are ignored, and `ovf_flag` keeps its value.
- R10: A read offered while the FIFO is empty has no effect on `level`, `dma_req` or the group counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low clears the data path |
| thr_cfg | input | 8 | Threshold in words per DMA request |
| wr_valid | input | 1 | Pin side offers a word this cycle |
| wr_data | input | DATA_W | Word from the pin side |
| rd_en | input | 1 | DMA pops the oldest word this cycle |
| rd_data | output | DATA_W | Oldest stored word |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| dma_req | output | 1 | Level DMA request, high while any group is owed |
| ovf_flag | output | 1 | Sticky receive overflow |
| ovf_clr | input | 1 | Write-one-to-clear for `ovf_flag` |

## Verification
The bench builds the block with `DEPTH` = 16 and 16-bit words. This makes filling the FIFO, overflowing it and clamping a large threshold to the depth cheap to reach in a few dozen cycles. With thresholds of 1 to 6 against a 16-word store, random traffic often makes write groups and read groups complete in the same cycle and in adjacent cycles. A behavioural queue model checks `dma_req`, `level`, `ovf_flag` and `rd_data` on every clock through those collisions.

// File: rtl/rxq_pkg.sv
// Package: shared constants for the receive FIFO request block.
// Assumes: threshold field is always 8 bits wide regardless of depth.
package rxq_pkg;
    localparam int THR_W   = 8;
    localparam int N_SIDES = 2;
    localparam int SIDE_WR = 0;
    localparam int SIDE_RD = 1;
endpackage

// File: rtl/rxq_store.sv
// Module: circular word store with occupancy count.
// Assumes: push is refused when full, pop is refused when empty; a pop and a
// push in one cycle are both honoured if each is legal on the entry state.
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     count,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              drop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              full, empty;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign push_ok   = push_req && !full;
    assign pop_ok    = pop_req && !empty;
    assign drop      = push_req && full;
    assign head_data = mem[rptr];

    // Purpose: advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Purpose: store accepted words.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Purpose: move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_chunk_count.sv
// Module: counts accepted transfers and pulses when a threshold group completes.
// Assumes: thr is already clamped to 1..DEPTH; a lowered threshold below the
// running count completes the group on the next transfer.
module rxq_chunk_count #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] thr,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;

    assign nxt  = {1'b0, cnt} + (CW + 1)'(1);
    assign done = step && (nxt >= {1'b0, thr});

    // Purpose: running count within the current group.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt <= '0;
        else if (done)        cnt <= '0;
        else if (step)        cnt <= nxt[CW-1:0];
    end
endmodule

// File: rtl/rxq_event_track.sv
// Module: owed-request counter; request is high while any group is owed.
// Assumes: read groups never outnumber write groups; floor at zero anyway.
module rxq_event_track #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic add,
    input  logic sub,
    output logic req
);
    logic [CW-1:0] owed;

    assign req = (owed != '0);

    // Purpose: net the set and clear events; coincident ones cancel.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else begin
            case ({add, sub})
                2'b10:   if (owed != CW'(DEPTH)) owed <= owed + CW'(1);
                2'b01:   if (owed != '0)         owed <= owed - CW'(1);
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/rxq_dma_event.sv
// Module: receive FIFO with threshold DMA request and sticky overflow.
// Assumes: one word per cycle per side; thr_cfg may change at any time and
// takes effect on the next transfer.
module rxq_dma_event #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [rxq_pkg::THR_W-1:0] thr_cfg,
    input  logic                     wr_valid,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic [CW-1:0]            level,
    output logic                     dma_req,
    output logic                     ovf_flag,
    input  logic                     ovf_clr
);
    import rxq_pkg::*;

    logic          clear;
    logic [CW-1:0] thr_eff;
    logic          push_ok, pop_ok, drop;
    logic          steps [N_SIDES];
    logic          dones [N_SIDES];
    logic          wr_done, rd_done;

    assign clear = !enable;

    // Purpose: clamp the programmed threshold into 1..DEPTH.
    always_comb begin
        if (thr_cfg == '0)              thr_eff = CW'(1);
        else if (int'(thr_cfg) > DEPTH) thr_eff = CW'(DEPTH);
        else                            thr_eff = CW'(thr_cfg);
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push_req  (wr_valid && enable),
        .push_data (wr_data),
        .pop_req   (rd_en && enable),
        .head_data (rd_data),
        .count     (level),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .drop      (drop)
    );

    assign steps[SIDE_WR] = push_ok;
    assign steps[SIDE_RD] = pop_ok;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        rxq_chunk_count #(.DEPTH(DEPTH)) u_chunk (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .step  (steps[s]),
            .thr   (thr_eff),
            .done  (dones[s])
        );
    end

    assign wr_done = dones[SIDE_WR];
    assign rd_done = dones[SIDE_RD];

    rxq_event_track #(.DEPTH(DEPTH)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .add   (wr_done),
        .sub   (rd_done),
        .req   (dma_req)
    );

    // Purpose: sticky overflow; a new drop wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (drop)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/rxq_dma_event_chk.sv
// Module: property checker bound to rxq_dma_event.
// Assumes: observes ports and the two group-done strobes.
module rxq_dma_event_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          wr_valid,
    input logic          rd_en,
    input logic [CW-1:0] level,
    input logic          dma_req,
    input logic          ovf_flag,
    input logic          ovf_clr,
    input logic          wr_done,
    input logic          rd_done
);
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        enable && wr_done && !rd_done |=> dma_req);

    a_r5_coincident_holds: assert property (@(posedge clk) disable iff (!rst_n)
        enable && wr_done && rd_done && dma_req |=> dma_req);

    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        enable && wr_valid && !rd_en && level == CW'(DEPTH)
        |=> ovf_flag && level == CW'(DEPTH));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> level == '0 && !dma_req);

    a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rd_en && !wr_valid && level == '0 |=> level == '0 && !rd_done);
endmodule

bind rxq_dma_event rxq_dma_event_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wr_valid (wr_valid),
    .rd_en    (rd_en),
    .level    (level),
    .dma_req  (dma_req),
    .ovf_flag (ovf_flag),
    .ovf_clr  (ovf_clr),
    .wr_done  (wr_done),
    .rd_done  (rd_done)
);

// File: tb/rxq_dma_event_tb.sv
module rxq_dma_event_tb;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 16;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [7:0]        thr_cfg = 8'd4;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              ovf_clr = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     level;
    logic              dma_req;
    logic              ovf_flag;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] seq = 16'h1000;

    // model state
    logic [DATA_W-1:0] mq[$];
    int m_wc = 0, m_rc = 0, m_owed = 0;
    bit m_ovf = 0;

    always #5 clk = ~clk;

    rxq_dma_event #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .thr_cfg(thr_cfg),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .level(level), .dma_req(dma_req),
        .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model updated on each edge, then compared 3 ns later.
    always @(posedge clk) begin
        int thr, sz;
        bit wd, rdn, dropw;
        thr = (thr_cfg == 0) ? 1 : ((int'(thr_cfg) > DEPTH) ? DEPTH : int'(thr_cfg));
        if (!rst_n) begin
            mq.delete(); m_wc = 0; m_rc = 0; m_owed = 0; m_ovf = 0;
        end else begin
            dropw = 0;
            if (!enable) begin
                mq.delete(); m_wc = 0; m_rc = 0; m_owed = 0;
            end else begin
                sz = mq.size(); wd = 0; rdn = 0;
                dropw = wr_valid && sz == DEPTH;
                if (rd_en && sz > 0) begin
                    void'(mq.pop_front());
                    m_rc++;
                    if (m_rc >= thr) begin m_rc = 0; rdn = 1; end
                end
                if (wr_valid && sz < DEPTH) begin
                    mq.push_back(wr_data);
                    m_wc++;
                    if (m_wc >= thr) begin m_wc = 0; wd = 1; end
                end
                if (wd && !rdn) m_owed++;
                else if (rdn && !wd && m_owed > 0) m_owed--;
            end
            if (dropw) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
        end
        #3;
        if (rst_n) begin
            chk("R2 level", int'(level), mq.size());
            chk("R3/R4/R5 dma_req", int'(dma_req), int'(m_owed != 0));
            chk("R7/R8 ovf_flag", int'(ovf_flag), int'(m_ovf));
            if (mq.size() > 0) chk("R2 rd_data", int'(rd_data), int'(mq[0]));
        end
    end

    task automatic step(input bit wv, input bit re);
        @(negedge clk);
        wr_valid = wv; rd_en = re; ovf_clr = 1'b0;
        if (wv) begin seq = seq + 16'd1; wr_data = seq; end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 0; rd_en = 0; ovf_clr = 0;
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        chk("R1 level", int'(level), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        enable = 1; thr_cfg = 8'd4;
        for (int i = 0; i < 3; i++) step(1, 0);
        idle();
        chk("R3 no req before group", int'(dma_req), 0);
        step(1, 0); idle();
        chk("R3 req after group", int'(dma_req), 1);
        chk("R2 level four", int'(level), 4);
        for (int i = 0; i < 3; i++) step(0, 1);
        idle();
        chk("R4 req held mid group", int'(dma_req), 1);
        step(0, 1); idle();
        chk("R4 req cleared", int'(dma_req), 0);
        // coincident set/clear
        thr_cfg = 8'd2;
        step(1, 0); step(1, 0);
        for (int i = 0; i < 10; i++) step(1, 1);
        idle();
        chk("R5 req kept", int'(dma_req), 1);
        chk("R5 level", int'(level), 2);
        step(0, 1); step(0, 1); idle();
        chk("R4 drained", int'(dma_req), 0);
        // threshold clamps
        thr_cfg = 8'd0;
        step(1, 0); idle();
        chk("R6 zero acts as one", int'(dma_req), 1);
        step(0, 1); idle();
        chk("R6 zero read", int'(dma_req), 0);
        thr_cfg = 8'd200;
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0);
        idle();
        chk("R6 clamp not yet", int'(dma_req), 0);
        step(1, 0); idle();
        chk("R6 clamp to depth", int'(dma_req), 1);
        // overflow
        step(1, 0); idle();
        chk("R7 ovf set", int'(ovf_flag), 1);
        chk("R7 level full", int'(level), DEPTH);
        step(1, 1); idle();
        chk("R7 read does not make room", int'(level), DEPTH - 1);
        step(1, 0);
        @(negedge clk); wr_valid = 1; rd_en = 0; ovf_clr = 1;
        idle();
        chk("R8 set wins over clear", int'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1;
        idle();
        chk("R8 cleared", int'(ovf_flag), 0);
        step(1, 0); idle();
        // disable
        enable = 0; idle();
        chk("R9 level cleared", int'(level), 0);
        chk("R9 req cleared", int'(dma_req), 0);
        chk("R9 ovf kept", int'(ovf_flag), 1);
        step(1, 0); idle();
        chk("R9 write ignored", int'(level), 0);
        enable = 1; @(negedge clk); ovf_clr = 1; idle();
        // empty read
        thr_cfg = 8'd1;
        step(0, 1); idle();
        chk("R10 level", int'(level), 0);
        chk("R10 req", int'(dma_req), 0);
        step(1, 0); idle();
        chk("R10 group count untouched", int'(dma_req), 1);
        step(0, 1); idle();
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) thr_cfg = 8'($urandom_range(1, 6));
            @(negedge clk);
            wr_valid = ($urandom_range(0, 99) < 55);
            rd_en    = ($urandom_range(0, 99) < 50);
            ovf_clr  = ($urandom_range(0, 99) < 3);
            if (wr_valid) begin seq = seq + 16'd1; wr_data = seq; end
            if (i % 997 == 500) enable = 0;
            else enable = 1;
        end
        idle(); idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule